// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block runs source-side main-link training for a DisplayPort transmitter. A start pulse begins a training run at a chosen link rate. The block then works through clock recovery and channel equalization. It reaches the sink's configuration registers through a simple request/acknowledge port: it writes the training-pattern register and the four per-lane drive-setting registers, and it reads a one-byte link-status summary. The summary carries clock-recovery-ok, equalization-ok and the sink's requested voltage-swing and pre-emphasis levels.

If a phase fails, the block drops one link-rate step and starts training again from the beginning. It gives up with an error only when a phase fails at the lowest rate. After training succeeds it clears the pattern, enters the send-video state and waits a programmable number of cycles for a ready-for-video indication. All settling waits are cycle counts supplied on input ports. An error acknowledge on the access port aborts the run at once.

Top module: `link_train_seq`

## Requirements
- R1: After reset the block is idle. `busy_o`, `done_o`, `req_o` and `video_on_o` are low, and `err_o` and `rate_o` are 0.
- R2: The training-pattern register is at address 0x102. Clock recovery writes 0x21 there (pattern 1 with the recovered-clock-out bit 0x20). Equalization writes 0x23 when `tps3_ok_i` is high and 0x22 when it is low.
- R3: Each training attempt starts with voltage and pre-emphasis at level 0. The drive byte is written to addresses 0x103, 0x104, 0x105 and 0x106, in that order, before every status read.
- R4: A drive byte holds the voltage level in bits 1:0 and the pre-emphasis level in bits 4:3. Bit 2 is set when the voltage is 3 and bit 5 when the pre-emphasis is 3. Bits 7:6 are 0. After a failed status read, the next drive byte carries the levels the sink requested.
- R5: In clock recovery, a status read at the maximum voltage fails the phase. A read at the same voltage as the previous read increments a try count, and the phase fails when that count reaches 5. A change of voltage clears the count.
- R6: In equalization the phase passes on equalization-ok. A failed read increments a try count, and the phase fails on the read at which the count is already above 5, which is the seventh failed read.
- R7: A failed phase steps `rate_o` down one code (3 = 8.1, 2 = 5.4, 1 = 2.7, 0 = 1.62 Gb/s) and restarts from clock recovery. A failure at code 0 ends the run with `err_o` = 1. The rate never rises during a run.
- R8: Every attempt ends with a write of 0 to the pattern register, followed by at least `eq_wait_i` cycles before the next access.
- R9: After success `video_on_o` rises. Ready-for-video within `video_limit_i` cycles ends the run with `err_o` = 0 and `video_on_o` still high. Otherwise the run ends with `err_o` = 3 and `video_on_o` low. `done_o` is a single-cycle pulse.
- R10: An error acknowledge ends the run at once with `err_o` = 2, and no further requests are issued.
- R11: The status is read from address 0x202. Bit 0 is clock-recovery-ok, bit 1 equalization-ok, bits 3:2 the requested voltage and bits 5:4 the requested pre-emphasis. Each read follows the last drive write by more than `cr_wait_i` cycles in clock recovery or `eq_wait_i` cycles in equalization. A request holds its address and data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a training run (sampled when idle) |
| tps3_ok_i | input | 1 | Sink supports training pattern 3 |
| rate_init_i | input | 2 | Starting link-rate code |
| cr_wait_i | input | CNT_W | Clock-recovery settle cycles |
| eq_wait_i | input | CNT_W | Equalization settle cycles |
| video_limit_i | input | VID_W | Ready-for-video timeout in cycles |
| video_ready_i | input | 1 | Ready-for-video event |
| req_o | output | 1 | Access request, held until acknowledge |
| req_wr_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | 16 | Sink register address |
| req_wdata_o | output | 8 | Write data |
| ack_i | input | 1 | Access acknowledge |
| ack_err_i | input | 1 | Acknowledge carries an error |
| ack_rdata_i | input | 6 | Link-status summary on read acknowledge |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 2 | 0 ok, 1 training failed, 2 access error, 3 video timeout |
| rate_o | output | 2 | Current link-rate code |
| video_on_o | output | 1 | Send-video state active |

## Verification
The bound checker checks the following on every cycle: requests stay stable until they are acknowledged, and every drive byte on the port is well-formed. It also checks that pattern writes carry only the four legal values, that reads go only to the status address, and that the rate never climbs within a run. It further checks that no request appears while idle and that `done_o` lasts one cycle. Only the bench's sink model can show the counting behaviour. This covers the five-read stall limit, the four-read climb to maximum voltage, the seven-read equalization limit, the sequence of rate fallbacks, the reset of levels between attempts, the settle gaps and the video timeout. It does this by scripting the sink's answers and counting the reads the block makes.

// File: rtl/lt_pkg.sv
package lt_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_INIT, S_PAT, S_DRV, S_WAIT, S_STAT, S_EVAL, S_CLR, S_CLRW, S_VIDEO
  } lt_state_e;

  typedef enum logic [1:0] {END_RETRY, END_PASS, END_FAIL} lt_end_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0, ERR_TRAIN = 2'd1, ERR_ACCESS = 2'd2, ERR_VIDEO = 2'd3
  } lt_err_e;

  typedef struct packed {
    logic [1:0] want_pe;
    logic [1:0] want_vs;
    logic       eq_ok;
    logic       cr_ok;
  } lt_status_t;

  localparam logic [15:0] ADDR_PATTERN = 16'h0102;
  localparam logic [15:0] ADDR_DRIVE0  = 16'h0103;
  localparam logic [15:0] ADDR_STATUS  = 16'h0202;

  localparam logic [7:0] PAT_CLK_OUT = 8'h20;
  localparam logic [7:0] PAT_ONE     = 8'h01;
  localparam logic [7:0] PAT_TWO     = 8'h02;
  localparam logic [7:0] PAT_THREE   = 8'h03;

  localparam logic [1:0] LVL_MAX = 2'd3;

endpackage

// File: rtl/lt_drive_enc.sv
module lt_drive_enc (
  input  logic [1:0] vs,
  input  logic [1:0] pe,
  output logic [7:0] code
);
  // byte layout: [5] pe at max, [4:3] pe, [2] swing at max, [1:0] swing
  always_comb begin
    code = {2'b00, &pe, pe, &vs, vs};
  end
endmodule

// File: rtl/lt_cycle_timer.sv
module lt_cycle_timer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] count,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= count;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
  import lt_pkg::*;
#(
  parameter int CNT_W        = 20,
  parameter int VID_W        = 28,
  parameter int N_DRV        = 4,
  parameter int CR_STALL_MAX = 5,
  parameter int EQ_TRY_MAX   = 5,
  parameter int TRY_W        = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             tps3_ok_i,
  input  logic [1:0]       rate_init_i,
  input  logic [CNT_W-1:0] cr_wait_i,
  input  logic [CNT_W-1:0] eq_wait_i,
  input  logic [VID_W-1:0] video_limit_i,
  input  logic             video_ready_i,
  output logic             req_o,
  output logic             req_wr_o,
  output logic [15:0]      req_addr_o,
  output logic [7:0]       req_wdata_o,
  input  logic             ack_i,
  input  logic             ack_err_i,
  input  logic [5:0]       ack_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       err_o,
  output logic [1:0]       rate_o,
  output logic             video_on_o
);

  localparam int IDX_W = (N_DRV > 1) ? $clog2(N_DRV) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(N_DRV - 1);
  localparam logic [TRY_W-1:0] CR_LAST   = TRY_W'(CR_STALL_MAX - 1);
  localparam logic [TRY_W-1:0] EQ_LIMIT  = TRY_W'(EQ_TRY_MAX);

  lt_state_e        state_q;
  lt_end_e          end_q;
  logic             phase_q;     // 0 clock recovery, 1 equalization
  logic [1:0]       vs_q, pe_q, old_vs_q;
  logic [TRY_W-1:0] tries_q;
  logic [IDX_W-1:0] drv_idx_q;
  logic [1:0]       rate_q;
  lt_status_t       stat_q;
  logic             req_q, req_wr_q, busy_q, done_q, vid_q;
  logic [15:0]      addr_q;
  logic [7:0]       wdata_q;
  logic [1:0]       err_q;

  logic [7:0]       drv_code;
  logic             acc_ok, acc_bad;
  logic             wt_load, wt_exp, vt_load, vt_exp;
  logic [CNT_W-1:0] wt_val;
  logic             ev_pass, ev_fail;
  logic [7:0]       pat_code;

  lt_drive_enc u_enc (.vs(vs_q), .pe(pe_q), .code(drv_code));

  lt_cycle_timer #(.W(CNT_W)) u_wait_tmr (
    .clk(clk), .rst(rst), .load(wt_load), .count(wt_val), .expired(wt_exp));

  lt_cycle_timer #(.W(VID_W)) u_vid_tmr (
    .clk(clk), .rst(rst), .load(vt_load), .count(video_limit_i), .expired(vt_exp));

  assign acc_ok  = req_q && ack_i && !ack_err_i;
  assign acc_bad = req_q && ack_i && ack_err_i;

  always_comb begin
    if (!phase_q)       pat_code = PAT_ONE | PAT_CLK_OUT;
    else if (tps3_ok_i) pat_code = PAT_THREE | PAT_CLK_OUT;
    else                pat_code = PAT_TWO | PAT_CLK_OUT;
  end

  always_comb begin
    wt_load = 1'b0;
    wt_val  = cr_wait_i;
    vt_load = 1'b0;
    if (state_q == S_DRV && acc_ok && drv_idx_q == IDX_LAST) begin
      wt_load = 1'b1;
      wt_val  = phase_q ? eq_wait_i : cr_wait_i;
    end
    if (state_q == S_CLR && acc_ok) begin
      wt_load = 1'b1;
      wt_val  = eq_wait_i;
    end
    if (state_q == S_CLRW && wt_exp && end_q == END_PASS) vt_load = 1'b1;
  end

  always_comb begin
    ev_pass = phase_q ? stat_q.eq_ok : stat_q.cr_ok;
    ev_fail = 1'b0;
    if (!ev_pass) begin
      if (!phase_q)
        ev_fail = (vs_q == LVL_MAX) || ((vs_q == old_vs_q) && (tries_q == CR_LAST));
      else
        ev_fail = (tries_q > EQ_LIMIT);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      end_q     <= END_RETRY;
      phase_q   <= 1'b0;
      vs_q      <= '0;
      pe_q      <= '0;
      old_vs_q  <= '0;
      tries_q   <= '0;
      drv_idx_q <= '0;
      rate_q    <= '0;
      stat_q    <= '0;
      req_q     <= 1'b0;
      req_wr_q  <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      vid_q     <= 1'b0;
      err_q     <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            rate_q  <= rate_init_i;
            busy_q  <= 1'b1;
            err_q   <= ERR_NONE;
            vid_q   <= 1'b0;
            state_q <= S_INIT;
          end
        end
        S_INIT: begin
          vs_q     <= '0;
          pe_q     <= '0;
          old_vs_q <= '0;
          tries_q  <= '0;
          phase_q  <= 1'b0;
          state_q  <= S_PAT;
        end
        S_PAT: begin
          if (!req_q) begin
            req_q    <= 1'b1;
            req_wr_q <= 1'b1;
            addr_q   <= ADDR_PATTERN;
            wdata_q  <= pat_code;
          end else if (acc_ok) begin
            req_q     <= 1'b0;
            drv_idx_q <= '0;
            state_q   <= S_DRV;
          end
        end
        S_DRV: begin
          if (!req_q) begin
            req_q    <= 1'b1;
            req_wr_q <= 1'b1;
            addr_q   <= ADDR_DRIVE0 + 16'(drv_idx_q);
            wdata_q  <= drv_code;
          end else if (acc_ok) begin
            req_q <= 1'b0;
            if (drv_idx_q == IDX_LAST) state_q <= S_WAIT;
            else drv_idx_q <= drv_idx_q + 1'b1;
          end
        end
        S_WAIT: begin
          if (wt_exp) state_q <= S_STAT;
        end
        S_STAT: begin
          if (!req_q) begin
            req_q    <= 1'b1;
            req_wr_q <= 1'b0;
            addr_q   <= ADDR_STATUS;
            wdata_q  <= '0;
          end else if (acc_ok) begin
            req_q   <= 1'b0;
            stat_q  <= lt_status_t'(ack_rdata_i);
            state_q <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (ev_pass) begin
            if (!phase_q) begin
              phase_q <= 1'b1;
              tries_q <= '0;
              state_q <= S_PAT;
            end else begin
              end_q   <= END_PASS;
              state_q <= S_CLR;
            end
          end else if (ev_fail) begin
            if (rate_q != 2'd0) begin
              rate_q <= rate_q - 2'd1;
              end_q  <= END_RETRY;
            end else begin
              end_q  <= END_FAIL;
            end
            state_q <= S_CLR;
          end else begin
            vs_q      <= stat_q.want_vs;
            pe_q      <= stat_q.want_pe;
            drv_idx_q <= '0;
            state_q   <= S_DRV;
            if (phase_q || (vs_q == old_vs_q)) begin
              tries_q <= tries_q + 1'b1;
            end else begin
              tries_q  <= '0;
              old_vs_q <= vs_q;
            end
          end
        end
        S_CLR: begin
          if (!req_q) begin
            req_q    <= 1'b1;
            req_wr_q <= 1'b1;
            addr_q   <= ADDR_PATTERN;
            wdata_q  <= 8'h00;
          end else if (acc_ok) begin
            req_q   <= 1'b0;
            state_q <= S_CLRW;
          end
        end
        S_CLRW: begin
          if (wt_exp) begin
            case (end_q)
              END_RETRY: state_q <= S_INIT;
              END_PASS: begin
                vid_q   <= 1'b1;
                state_q <= S_VIDEO;
              end
              default: begin
                err_q   <= ERR_TRAIN;
                busy_q  <= 1'b0;
                done_q  <= 1'b1;
                state_q <= S_IDLE;
              end
            endcase
          end
        end
        S_VIDEO: begin
          if (video_ready_i) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (vt_exp) begin
            vid_q   <= 1'b0;
            err_q   <= ERR_VIDEO;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
      if (acc_bad) begin
        req_q   <= 1'b0;
        err_q   <= ERR_ACCESS;
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        state_q <= S_IDLE;
      end
    end
  end

  assign req_o       = req_q;
  assign req_wr_o    = req_wr_q;
  assign req_addr_o  = addr_q;
  assign req_wdata_o = wdata_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign rate_o      = rate_q;
  assign video_on_o  = vid_q;

endmodule

// File: rtl/lt_seq_chk.sv
module lt_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_o,
  input logic        req_wr_o,
  input logic [15:0] req_addr_o,
  input logic [7:0]  req_wdata_o,
  input logic        ack_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [1:0]  err_o,
  input logic [1:0]  rate_o,
  input logic        video_on_o
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> (req_o && $stable(req_addr_o) && $stable(req_wdata_o) && $stable(req_wr_o))); // R11

  AST_STATUS_ADDR: assert property (@(posedge clk) disable iff (rst)
    (req_o && !req_wr_o) |-> (req_addr_o == 16'h0202)); // R11

  AST_PATTERN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (req_o && req_wr_o && req_addr_o == 16'h0102) |->
      (req_wdata_o inside {8'h00, 8'h21, 8'h22, 8'h23})); // R2

  AST_DRIVE_FORMAT: assert property (@(posedge clk) disable iff (rst)
    (req_o && req_wr_o && req_addr_o >= 16'h0103 && req_addr_o <= 16'h0106) |->
      (req_wdata_o[7:6] == 2'b00 && req_wdata_o[2] == (&req_wdata_o[1:0]) &&
       req_wdata_o[5] == (&req_wdata_o[4:3]))); // R4

  AST_RATE_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (rate_o <= $past(rate_o))); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !req_o); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9

  AST_VIDEO_OK: assert property (@(posedge clk) disable iff (rst)
    (done_o && video_on_o) |-> (err_o == 2'd0)); // R9

endmodule

bind link_train_seq lt_seq_chk u_chk (
  .clk(clk), .rst(rst), .req_o(req_o), .req_wr_o(req_wr_o),
  .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o), .ack_i(ack_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rate_o(rate_o),
  .video_on_o(video_on_o)
);

// File: tb/link_train_seq_tb.sv
`timescale 1ns/1ps
module link_train_seq_tb;

  localparam int CNT_W = 20;
  localparam int VID_W = 28;
  localparam int CRW   = 4;
  localparam int EQW   = 6;

  typedef struct packed {
    logic [1:0] rate;
    logic       tps3;
    logic [1:0] crm;     // 0 ok, 1 stall, 2 climb, 3 ok only at code<=1
    logic [1:0] eqm;     // 0 ok, 1 never, 2 ok on fourth read
    logic       vnever;
    logic       aerr;
    logic [1:0] xerr;
    logic [1:0] xrate;
    logic [7:0] xreads;
    logic [7:0] xeqpat;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd3, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd3, 8'd2,  8'h23},
    '{2'd2, 1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 2'd0, 2'd2, 8'd5,  8'h22},
    '{2'd1, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 2'd1, 2'd0, 8'd10, 8'h00},
    '{2'd0, 1'b1, 2'd2, 2'd0, 1'b0, 1'b0, 2'd1, 2'd0, 8'd4,  8'h00},
    '{2'd3, 1'b1, 2'd3, 2'd0, 1'b0, 1'b0, 2'd0, 2'd1, 8'd12, 8'h23},
    '{2'd0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 2'd1, 2'd0, 8'd8,  8'h22},
    '{2'd2, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 2'd3, 2'd2, 8'd2,  8'h22},
    '{2'd1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 2'd2, 2'd1, 8'd1,  8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, tps3_ok_i = 1'b0;
  logic [1:0] rate_init_i = '0;
  logic [CNT_W-1:0] cr_wait_i = CNT_W'(CRW);
  logic [CNT_W-1:0] eq_wait_i = CNT_W'(EQW);
  logic [VID_W-1:0] video_limit_i = VID_W'(50);
  logic video_ready_i = 1'b0;
  logic req_o, req_wr_o;
  logic [15:0] req_addr_o;
  logic [7:0] req_wdata_o;
  logic ack_i = 1'b0, ack_err_i = 1'b0;
  logic [5:0] ack_rdata_i = '0;
  logic busy_o, done_o, video_on_o;
  logic [1:0] err_o, rate_o;

  always #2.5 clk = ~clk;

  link_train_seq u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .tps3_ok_i(tps3_ok_i),
    .rate_init_i(rate_init_i), .cr_wait_i(cr_wait_i), .eq_wait_i(eq_wait_i),
    .video_limit_i(video_limit_i), .video_ready_i(video_ready_i),
    .req_o(req_o), .req_wr_o(req_wr_o), .req_addr_o(req_addr_o),
    .req_wdata_o(req_wdata_o), .ack_i(ack_i), .ack_err_i(ack_err_i),
    .ack_rdata_i(ack_rdata_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .rate_o(rate_o), .video_on_o(video_on_o)
  );

  int nchk = 0, nfail = 0;
  vec_t cur = '0;
  // sink model state
  int reads, reqs, eq_reads, drv_err, addr_err, gap_err, cyc, mark_cyc, mark_need, vid_cnt;
  logic mark_on, in_eq, vid_done;
  logic [1:0] exp_v, exp_p;
  logic [7:0] seen_eqpat, last_pat;
  logic [15:0] drv_next;

  function automatic logic [7:0] enc(input logic [1:0] v, input logic [1:0] p);
    logic [7:0] b;
    b = {6'd0, v};
    b = b | ({6'd0, p} << 3);
    if (v == 2'd3) b = b | 8'h04;
    if (p == 2'd3) b = b | 8'h20;
    return b;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    reads = 0; reqs = 0; eq_reads = 0; drv_err = 0; addr_err = 0; gap_err = 0;
    mark_on = 1'b0; in_eq = 1'b0; vid_done = 1'b0; vid_cnt = 0;
    exp_v = 0; exp_p = 0; seen_eqpat = 0; last_pat = 8'hFF; drv_next = 16'h0103;
  endtask

  // sink responder and video source
  initial begin
    logic ok;
    logic [1:0] nv, np;
    cyc = 0;
    clear_model();
    forever begin
      @(negedge clk);
      cyc++;
      if (req_o && !ack_i) begin
        ack_i = 1'b1; ack_err_i = 1'b0; ack_rdata_i = '0;
        reqs++;
        if (mark_on) begin
          if (cyc - mark_cyc <= mark_need) gap_err++;
          mark_on = 1'b0;
        end
        if (req_wr_o) begin
          if (req_addr_o == 16'h0102) begin
            last_pat = req_wdata_o;
            if (req_wdata_o == 8'h21) begin
              exp_v = 0; exp_p = 0; in_eq = 1'b0; drv_next = 16'h0103;
            end else if (req_wdata_o == 8'h22 || req_wdata_o == 8'h23) begin
              seen_eqpat = req_wdata_o; in_eq = 1'b1; eq_reads = 0; drv_next = 16'h0103;
            end else begin
              mark_on = 1'b1; mark_cyc = cyc; mark_need = EQW;
            end
          end else begin
            if (req_addr_o != drv_next) addr_err++;
            drv_next = drv_next + 16'd1;
            if (req_wdata_o != enc(exp_v, exp_p)) drv_err++;
            if (req_addr_o == 16'h0106) begin
              mark_on = 1'b1; mark_cyc = cyc; mark_need = in_eq ? EQW : CRW;
            end
          end
        end else begin
          reads++;
          drv_next = 16'h0103;
          if (cur.aerr) ack_err_i = 1'b1;
          nv = exp_v; np = exp_p; ok = 1'b1;
          if (!in_eq) begin
            case (cur.crm)
              2'd1: begin ok = 1'b0; np = 2'd1; end
              2'd2: begin ok = 1'b0; nv = (exp_v == 2'd3) ? 2'd3 : exp_v + 2'd1; np = nv; end
              2'd3: begin ok = (rate_o <= 2'd1); if (!ok) begin nv = 0; np = 0; end end
              default: ok = 1'b1;
            endcase
            ack_rdata_i = {np, nv, 1'b0, ok};
          end else begin
            case (cur.eqm)
              2'd1: begin ok = 1'b0; nv = 2'd1; np = 2'd2; end
              2'd2: begin ok = (eq_reads >= 3); if (!ok) begin nv = 2'd1; np = 2'd1; end end
              default: ok = 1'b1;
            endcase
            eq_reads++;
            ack_rdata_i = {np, nv, ok, 1'b1};
          end
          if (!ok) begin exp_v = nv; exp_p = np; end
        end
      end else begin
        ack_i = 1'b0; ack_err_i = 1'b0;
      end
      if (video_on_o && !vid_done && !cur.vnever) begin
        vid_cnt++;
        if (vid_cnt == 10) begin video_ready_i = 1'b1; vid_done = 1'b1; end
      end else begin
        video_ready_i = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 req", req_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 rate", rate_o, 0);
    chk("R1 video", video_on_o, 0);

    for (int i = 0; i < 8; i++) begin
      int waited;
      int reqs_at_done;
      logic got;
      cur = VECS[i];
      clear_model();
      rate_init_i = cur.rate;
      tps3_ok_i = cur.tps3;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      got = 1'b0;
      waited = 0;
      while (!got && waited < 20000) begin
        @(negedge clk);
        waited++;
        if (done_o) got = 1'b1;
      end
      chk("R9 done seen", got, 1);
      chk(cur.xerr == 2'd1 ? "R7 final error" : (cur.xerr == 2'd3 ? "R9 timeout error" :
          (cur.xerr == 2'd2 ? "R10 abort error" : "R9 success error")), err_o, cur.xerr);
      chk("R7 final rate", rate_o, cur.xrate);
      chk("R5 R6 status reads", reads, cur.xreads);
      chk("R2 phase-two pattern", seen_eqpat, cur.xeqpat);
      chk("R3 R4 drive bytes", drv_err, 0);
      chk("R3 drive addresses", addr_err, 0);
      chk("R11 settle gaps", gap_err, 0);
      chk("R9 video state", video_on_o, (cur.xerr == 2'd0) ? 1 : 0);
      chk("R1 idle after run", busy_o, 0);
      if (cur.aerr) begin
        reqs_at_done = reqs;
        repeat (20) @(negedge clk);
        chk("R10 no request after abort", reqs - reqs_at_done, 0);
        chk("R10 last pattern", last_pat, 8'h21);
      end else begin
        chk("R8 pattern cleared", last_pat, 8'h00);
      end
      repeat (3) @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule